// File: doc/BRIEF.md
# Page Write Buffer Sequencer

This block sits behind the serial command front end of a byte-wide non-volatile memory. During a write sequence it receives a start address and then a stream of data bytes. It gathers these bytes in a page buffer of `PAGE_BYTES` entries (32 by default). The buffer keeps a per-location record of which bytes were loaded. Loading moves only within one page: the low offset bits advance after each byte and wrap to offset 0, while the page bits stay fixed. Once the page is full, further bytes overwrite earlier ones.

The front end signals the end of the sequence with a one-cycle strobe that marks the rise of chip select. If the `permit` input is high at that moment and at least one byte was loaded, the block enters a self-timed programming window. The window lasts exactly `WC_CYCLES` clocks, and `busy` stays high for all of it. In the first `PAGE_BYTES` cycles of the window, the block writes each loaded location to the array, one byte per clock, in ascending offset order. Unloaded locations are skipped. The remaining cycles only pad the window out to the configured length. When the window ends, `wr_done` pulses for one cycle so that the front end can clear its write-enable latch. An abort discards a sequence before it is committed.

Top module: `pgwr_seq`

## Requirements
- R1: After reset `busy`, `wr_done` and `arr_we` are 0 and the page buffer holds no loaded bytes, so a commit strobe alone starts nothing.
- R2: A `seq_start` strobe while idle captures `start_addr` and empties the buffer. The page is `start_addr[ADDR_W-1:5]` and the first offset is `start_addr[4:0]`. Each `byte_load` stores `byte_data` at the current offset and then advances the offset by one.
- R3: Loading past offset 31 wraps to offset 0 of the same page, and a later byte overwrites an earlier byte at the same offset.
- R4: In busy cycle k (k = 0 is the first busy cycle), for k < `PAGE_BYTES`, `arr_we` is 1 exactly when offset k was loaded. In that cycle `arr_addr` is {page, k} and `arr_wdata` is the last byte loaded at offset k. No array write happens at any other time.
- R5: A `cs_rise` while idle, with `permit` = 1 and at least one byte loaded, raises `busy` from the next cycle for exactly `WC_CYCLES` consecutive cycles.
- R6: A `cs_rise` while idle with `permit` = 0, or with no byte loaded, starts no programming window, and the loaded bytes are discarded.
- R7: `wr_done` is high for exactly one cycle: the cycle right after the last busy cycle.
- R8: An `abort` while idle discards all loaded bytes. Among simultaneous idle inputs the priority is abort, then `cs_rise`, then `seq_start`, then `byte_load`; the lower-priority inputs in that cycle are ignored.
- R9: While `busy` is 1, the inputs `seq_start`, `byte_load`, `cs_rise` and `abort` are ignored, and the window's writes are unchanged.
- R10: When a programming window ends, the buffer is empty, so a commit with no new loads starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_start | input | 1 | Begin a sequence: capture start address |
| start_addr | input | ADDR_W | Start byte address of the sequence |
| byte_load | input | 1 | Store one data byte |
| byte_data | input | DATA_W | Data byte to store |
| cs_rise | input | 1 | Chip-select rise strobe, commits the page |
| abort | input | 1 | Discard the sequence |
| permit | input | 1 | Allows the commit when high |
| busy | output | 1 | Programming window in progress |
| wr_done | output | 1 | One-cycle completion pulse |
| arr_we | output | 1 | Array byte write enable |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | DATA_W | Array byte data |

## Verification
The assertions assume that each input strobe is a single-cycle, synchronous pulse. They also assume that `WC_CYCLES` is at least `PAGE_BYTES`, so that the whole scan of the page fits inside the window. The stimulus drives every strobe for exactly one clock, away from the active edge, and uses a window of 40 cycles against a 32-byte page. It also deliberately stacks several strobes in one cycle, and fires all of them during a window, to exercise the priority and ignore rules.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PROG = 1'b1
    } seq_state_e;

    // Next offset inside a page of 'size' entries, wrapping to zero.
    function automatic int unsigned wrap_next(int unsigned off, int unsigned size);
        return (off + 1 == size) ? 0 : off + 1;
    endfunction

endpackage

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              addr_set,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [PG_W-1:0]   page_out,
    output logic              any_loaded
);
    import pgwr_pkg::*;

    logic [DATA_W-1:0]     store_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;
    logic [OFF_W-1:0]      ptr_q;
    logic [PG_W-1:0]       page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ptr_q  <= '0;
            page_q <= '0;
        end else if (clear) begin
            mask_q <= '0;
        end else if (addr_set) begin
            page_q <= addr_in[ADDR_W-1:OFF_W];
            ptr_q  <= addr_in[OFF_W-1:0];
            mask_q <= '0;
        end else if (load_en) begin
            mask_q[ptr_q] <= 1'b1;
            ptr_q         <= OFF_W'(wrap_next(int'(ptr_q), PAGE_BYTES));
        end
    end

    always_ff @(posedge clk) begin
        if (!clear && !addr_set && load_en)
            store_q[ptr_q] <= load_data;
    end

    assign rd_data    = store_q[rd_idx];
    assign rd_valid   = mask_q[rd_idx];
    assign page_out   = page_q;
    assign any_loaded = |mask_q;

    // R3
    wrap_in_page_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && !clear && !addr_set && ptr_q == OFF_W'(PAGE_BYTES-1))
        |=> (ptr_q == '0 && $stable(page_q)));

    // R2
    load_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && !clear && !addr_set) |=> any_loaded);

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter int WC_CYCLES = 64,
    localparam int CNT_W    = $clog2(WC_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             last,
    output logic             done,
    output logic [CNT_W-1:0] step
);
    import pgwr_pkg::*;

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    assign busy = (state_q == ST_PROG);
    assign last = busy && (cnt_q == CNT_W'(WC_CYCLES - 1));
    assign done = done_q;
    assign step = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_PROG;
                    cnt_q   <= '0;
                end
                ST_PROG: if (last) begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                    done_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && step == '0));

    // R5
    window_end_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> (!busy && done));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq #(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int WC_CYCLES  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_load,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              abort,
    input  logic              permit,
    output logic              busy,
    output logic              wr_done,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int CNT_W = $clog2(WC_CYCLES + 1);

    logic             busy_w, last_w, done_w;
    logic [CNT_W-1:0] step_w;
    logic             idle, abort_i, commit_i, go_i, drop_i, set_i, load_i;
    logic             any_loaded, rd_valid, in_scan;
    logic [DATA_W-1:0] rd_data;
    logic [PG_W-1:0]  page_w;
    logic [OFF_W-1:0] scan_idx;

    // Idle-time priority: abort, commit, address capture, byte load.
    assign idle     = !busy_w;
    assign abort_i  = idle && abort;
    assign commit_i = idle && !abort && cs_rise;
    assign go_i     = commit_i && permit && any_loaded;
    assign drop_i   = abort_i || (commit_i && !go_i);
    assign set_i    = idle && !abort && !cs_rise && seq_start;
    assign load_i   = idle && !abort && !cs_rise && !seq_start && byte_load;

    assign scan_idx = step_w[OFF_W-1:0];
    assign in_scan  = step_w < CNT_W'(PAGE_BYTES);

    pgwr_buf #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
    ) buf_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (drop_i || last_w),
        .addr_set  (set_i),
        .addr_in   (start_addr),
        .load_en   (load_i),
        .load_data (byte_data),
        .rd_idx    (scan_idx),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .page_out  (page_w),
        .any_loaded(any_loaded)
    );

    pgwr_timer #(.WC_CYCLES(WC_CYCLES)) tmr_i (
        .clk  (clk),
        .rst  (rst),
        .start(go_i),
        .busy (busy_w),
        .last (last_w),
        .done (done_w),
        .step (step_w)
    );

    assign busy      = busy_w;
    assign wr_done   = done_w;
    assign arr_we    = busy_w && in_scan && rd_valid;
    assign arr_addr  = {page_w, scan_idx};
    assign arr_wdata = rd_data;

    // R6
    no_permit_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && !busy && !permit) |=> !busy);

    // R4
    we_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    // R10
    empty_after_chk: assert property (@(posedge clk) disable iff (rst)
        last_w |=> !any_loaded);

    // R9
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_w) |=> $stable(arr_addr[ADDR_W-1:OFF_W]));

endmodule

// File: tb/pgwr_seq_tb.sv
module pgwr_seq_tb_top;
    localparam int AW = 13;
    localparam int WC = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          seq_start = 0, byte_load = 0, cs_rise = 0, abort = 0, permit = 0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    byte_data = '0;
    logic          busy, wr_done, arr_we;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata;

    always #4 clk = ~clk;

    pgwr_seq #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(32), .WC_CYCLES(WC)) dut_i (
        .clk(clk), .rst(rst), .seq_start(seq_start), .start_addr(start_addr),
        .byte_load(byte_load), .byte_data(byte_data), .cs_rise(cs_rise),
        .abort(abort), .permit(permit), .busy(busy), .wr_done(wr_done),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    int checks = 0, fails = 0;
    int wr_count = 0, busy_cycles = 0, wdog = 0;
    logic [7:0] mem [int];
    int wr_log [$];

    // behavioural reference state
    bit         m_busy = 0, m_done = 0;
    int         m_pos = 0, m_ptr = 0, m_page = 0;
    bit  [31:0] m_mask = '0;
    logic [7:0] m_buf [32];

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_pos = 0; m_ptr = 0; m_page = 0; m_mask = '0;
        end else if (m_busy) begin
            m_done = 0;
            if (m_pos == WC - 1) begin
                m_busy = 0; m_done = 1; m_mask = '0;
            end else m_pos++;
        end else begin
            m_done = 0;
            if (abort) m_mask = '0;
            else if (cs_rise) begin
                if (permit && m_mask != 0) begin m_busy = 1; m_pos = 0; end
                else m_mask = '0;
            end else if (seq_start) begin
                m_page = int'(start_addr) / 32; m_ptr = int'(start_addr) % 32; m_mask = '0;
            end else if (byte_load) begin
                m_buf[m_ptr] = byte_data; m_mask[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 32;
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            bit exp_we;
            exp_we = m_busy && m_pos < 32 && m_mask[m_pos];
            chk("R5 R6 R9", "busy", int'(busy), int'(m_busy));
            chk("R7", "wr_done", int'(wr_done), int'(m_done));
            chk("R4", "arr_we", int'(arr_we), int'(exp_we));
            if (exp_we && arr_we) begin
                chk("R4", "arr_addr", int'(arr_addr), m_page * 32 + m_pos);
                chk("R4", "arr_wdata", int'(arr_wdata), int'(m_buf[m_pos]));
            end
            if (arr_we) begin
                mem[int'(arr_addr)] = arr_wdata;
                wr_log.push_back(int'(arr_addr));
                wr_count++;
            end
            if (busy) busy_cycles++;
        end
    end

    task automatic cyc(bit s, logic [AW-1:0] a, bit l, logic [7:0] d, bit c, bit ab, bit p);
        seq_start = s; start_addr = a; byte_load = l; byte_data = d;
        cs_rise = c; abort = ab; permit = p;
        @(negedge clk);
        seq_start = 0; byte_load = 0; cs_rise = 0; abort = 0; permit = 0;
    endtask

    task automatic set_addr(logic [AW-1:0] a); cyc(1, a, 0, 0, 0, 0, 0); endtask
    task automatic load(logic [7:0] d);        cyc(0, 0, 1, d, 0, 0, 0); endtask
    task automatic commit(bit p);              cyc(0, 0, 0, 0, 1, 0, p); endtask
    task automatic idle(int n); repeat (n) @(negedge clk); endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        wdog++;
        if (wdog > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", wdog);
            summary();
        end
    end

    initial begin
        int w0, b0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "we after reset", int'(arr_we), 0);
        chk("R1", "done after reset", int'(wr_done), 0);
        b0 = busy_cycles;
        commit(1); idle(3);
        chk("R1", "commit with empty buffer", busy_cycles - b0, 0);

        // R2 R4 R5: simple four-byte write
        w0 = wr_count; b0 = busy_cycles;
        set_addr(13'h0123);
        for (int i = 0; i < 4; i++) load(8'hA0 + 8'(i));
        commit(1); idle(WC + 4);
        chk("R4", "write count", wr_count - w0, 4);
        chk("R2", "mem[0x123]", int'(mem[13'h123]), 8'hA0);
        chk("R2", "mem[0x126]", int'(mem[13'h126]), 8'hA3);
        chk("R5", "busy length", busy_cycles - b0, WC);

        // R3 wrap within page
        w0 = wr_count;
        set_addr(13'h005E);
        for (int i = 0; i < 34; i++) load(8'h10 + 8'(i));
        commit(1); idle(WC + 4);
        chk("R3", "write count", wr_count - w0, 32);
        chk("R3", "overwritten offset 30", int'(mem[13'h05E]), 8'h30);
        chk("R3", "overwritten offset 31", int'(mem[13'h05F]), 8'h31);
        chk("R3", "offset 0", int'(mem[13'h040]), 8'h12);

        // R6 permit low, then discarded buffer
        w0 = wr_count; b0 = busy_cycles;
        set_addr(13'h0200); load(8'h55);
        commit(0); idle(2);
        commit(1); idle(3);
        chk("R6", "no write when blocked", wr_count - w0, 0);
        chk("R6", "no busy when blocked", busy_cycles - b0, 0);

        // R8 abort, and same-cycle priority
        w0 = wr_count;
        set_addr(13'h0300); load(8'h66); load(8'h67);
        cyc(0, 0, 0, 0, 0, 1, 0);
        commit(1); idle(3);
        set_addr(13'h0300); load(8'h77);
        cyc(1, 13'h0310, 1, 8'h78, 1, 1, 1);
        commit(1); idle(3);
        chk("R8", "abort discards", wr_count - w0, 0);

        // R9 inputs ignored while busy; R10 empty afterwards
        w0 = wr_count;
        set_addr(13'h0400); load(8'h11); commit(1);
        idle(2);
        set_addr(13'h0500); load(8'h99); cyc(0, 0, 0, 0, 0, 1, 0); commit(1);
        idle(WC + 4);
        chk("R9", "window writes kept", wr_count - w0, 1);
        chk("R9", "mem[0x400]", int'(mem[13'h400]), 8'h11);
        chk("R9", "no write to ignored page", int'(mem.exists(13'h500)), 0);
        w0 = wr_count; b0 = busy_cycles;
        commit(1); idle(3);
        chk("R10", "buffer empty after window", busy_cycles - b0, 0);

        // R4 ascending order across wrap
        w0 = wr_count;
        wr_log.delete();
        set_addr(13'h07FF); load(8'hC3); load(8'hC4);
        commit(1); idle(WC + 4);
        chk("R4", "sparse write count", wr_count - w0, 2);
        chk("R4", "first address is offset 0", wr_log[0], 13'h7E0);
        chk("R4", "second address is offset 31", wr_log[1], 13'h7FF);
        chk("R4", "mem[0x7E0]", int'(mem[13'h7E0]), 8'hC4);

        summary();
    end
endmodule